// File: doc/BRIEF.md
# MSI Interrupt Message Generator

This block sits between a function's interrupt sources and its upstream request path. It turns a per-vector interrupt request into a single-beat posted memory-write request. The write carries a 64-bit address, a 32-bit data word and the function's requester ID. The address, data base, allocated vector count, mask bits and enable all come from the capability register file as live inputs. A pulse on `cfg_wr` tells the block that software has just written that register file.

When per-vector masking is built in, a request for a masked vector is not lost. It is recorded in a pending bitmap that software can read through `pend_o`. On the next configuration write made while the block is enabled, the block first drops any pending bits that lie outside the allocated range. It then releases every pending vector that is now unmasked. Messages waiting to go out are sent lowest vector first, one per valid/ready handshake. While MSI is enabled, the legacy level interrupt is forced inactive.

Top module: `msi_msg_gen`

## Requirements
- R1: A request whose vector is at or above the allocated count (2 to the power of the effective count field) raises `irq_err` for exactly one cycle, on the cycle after the request. It sets no pending bit and sends no message.
- R2: With masking built in (MASK_EN=1), a request for a vector whose `cfg_mask` bit is 1 sets `pend_o` bit [vector] one cycle later and sends no message. A repeat request while that bit is set leaves it set, so only one event is recorded.
- R3: With masking left out (MASK_EN=0), `pend_o` stays 0 and every legal request produces a message, whatever `cfg_mask` holds.
- R4: Message data bits 31:16 are 0. Bits 15:0 are `cfg_data` with its low L bits replaced by the low L bits of the vector number, where L is the effective count field. When L is 0, `cfg_data` is sent unchanged.
- R5: With ADDR64_EN=1, `msg_addr` equals `cfg_addr`. With ADDR64_EN=0, `msg_addr` is `cfg_addr[31:0]` zero-extended to 64 bits.
- R6: Once `msg_valid` is 1, it and `msg_addr`, `msg_data` and `msg_rid` stay unchanged until a cycle with `msg_ready` high. Each such handshake ends exactly one message. `msg_rid` carries `req_id` as captured when the message was launched.
- R7: Unmasked requests that are waiting for the request port are issued lowest vector number first.
- R8: A `cfg_wr` pulse while enabled moves every pending, unmasked, in-range vector out of the pending bitmap and into the send queue. Those vectors are then sent in ascending order, behind any message already on the port.
- R9: A `cfg_wr` pulse while enabled clears every pending bit at or above the allocated count, and sends no message for those bits.
- R10: `intx_o` equals `intx_i` while `cfg_enable` is 0, and is 0 while `cfg_enable` is 1.
- R11: While `cfg_enable` is 0, requests raise no error and change no pending bit, `cfg_wr` changes no pending bit, and no new message is launched.
- R12: A count field above log2(NUM_VEC) is treated as log2(NUM_VEC) for range checks and data composition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | MSI enable from the capability registers |
| cfg_log_vecs | input | LOGF_W | log2 of the allocated vector count |
| cfg_addr | input | 64 | Message address register |
| cfg_data | input | 16 | Message data base register |
| cfg_mask | input | NUM_VEC | Per-vector mask bits |
| cfg_wr | input | 1 | One-cycle pulse after a configuration write |
| req_id | input | 16 | Requester ID of the function |
| irq_valid | input | 1 | Interrupt request strobe |
| irq_vec | input | VEC_W | Vector number of the request |
| irq_err | output | 1 | Out-of-range request seen |
| pend_o | output | NUM_VEC | Pending bitmap |
| intx_i | input | 1 | Legacy interrupt request from the device |
| intx_o | output | 1 | Legacy interrupt request after gating |
| msg_valid | output | 1 | Memory-write request valid |
| msg_ready | input | 1 | Memory-write request accepted |
| msg_addr | output | 64 | Write address |
| msg_data | output | 32 | Write data, little-endian dword |
| msg_rid | output | 16 | Requester ID tag |

## Verification
The embedded assertions check four things on every cycle:
- The outgoing request is held steady while it waits for `msg_ready`.
- The pending bitmap is frozen while the block is disabled, and is untouched by an out-of-range request.
- The send queue is always served from its lowest set vector.

Some behaviour only the bench scenarios can show:
- The ascending replay order after a configuration write.
- The discarding of out-of-range pending bits.
- The data-word substitution and count clamping.
- The behaviour of the variant built without masking and without the upper address word.

The bench checks these with a behavioural model compared every cycle, plus a log of delivered messages.

// File: rtl/msi_gen_pkg.sv
package msi_gen_pkg;

   localparam int MSG_ADDR_W  = 64;
   localparam int MSG_DATA_W  = 32;
   localparam int BASE_DATA_W = 16;
   localparam int RID_W       = 16;

   typedef struct packed {
      logic [MSG_ADDR_W-1:0] addr;
      logic [MSG_DATA_W-1:0] data;
      logic [RID_W-1:0]      rid;
   } msi_msg_t;

endpackage

// File: rtl/msi_vec_track.sv
module msi_vec_track #(
   parameter int NUM_VEC = 32,
   parameter bit MASK_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               cfg_wr,
   input  logic [NUM_VEC-1:0] req_hit,
   input  logic [NUM_VEC-1:0] mask,
   input  logic [NUM_VEC-1:0] in_range,
   input  logic [NUM_VEC-1:0] launch,
   output logic [NUM_VEC-1:0] pend,
   output logic [NUM_VEC-1:0] fire
);

   logic [NUM_VEC-1:0] direct_set;
   logic [NUM_VEC-1:0] released;
   logic [NUM_VEC-1:0] fire_nxt;

   generate
      if (MASK_EN) begin : g_masked
         logic [NUM_VEC-1:0] pend_q;
         logic [NUM_VEC-1:0] masked_set;
         logic [NUM_VEC-1:0] pend_nxt;
         logic               rescan;

         assign rescan     = en && cfg_wr;
         assign masked_set = req_hit & mask;
         assign direct_set = req_hit & ~mask;
         assign released   = rescan ? (pend_q & in_range & ~mask) : '0;

         always_comb begin
            pend_nxt = pend_q;
            if (rescan) begin
               pend_nxt = pend_q & in_range & mask;
            end
            pend_nxt = pend_nxt | masked_set;
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pend_q <= '0;
            end else begin
               pend_q <= pend_nxt;
            end
         end

         assign pend = pend_q;

         AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            !en |=> $stable(pend_q)); // R11
      end else begin : g_plain
         assign direct_set = req_hit;
         assign released   = '0;
         assign pend       = '0;
      end
   endgenerate

   assign fire_nxt = (fire & ~launch) | direct_set | released;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fire <= '0;
      end else begin
         fire <= fire_nxt;
      end
   end

endmodule

// File: rtl/msi_lowest_pick.sv
module msi_lowest_pick #(
   parameter int NUM_VEC = 32,
   localparam int VEC_W  = $clog2(NUM_VEC)
) (
   input  logic [NUM_VEC-1:0] req,
   output logic [NUM_VEC-1:0] gnt,
   output logic [VEC_W-1:0]   idx,
   output logic               any
);

   assign gnt = req & (~req + 1'b1);
   assign any = |req;

   always_comb begin
      idx = '0;
      for (int i = NUM_VEC - 1; i >= 0; i--) begin
         if (req[i]) begin
            idx = VEC_W'(i);
         end
      end
   end

endmodule

// File: rtl/msi_msg_out.sv
module msi_msg_out
   import msi_gen_pkg::*;
#(
   parameter int NUM_VEC   = 32,
   parameter bit ADDR64_EN = 1'b1,
   parameter int LOGF_W    = 3,
   localparam int VEC_W    = $clog2(NUM_VEC)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   go,
   input  logic [VEC_W-1:0]       vec,
   input  logic [LOGF_W-1:0]      eff_log,
   input  logic [MSG_ADDR_W-1:0]  base_addr,
   input  logic [BASE_DATA_W-1:0] base_data,
   input  logic [RID_W-1:0]       rid,
   input  logic                   ready,
   output logic                   valid,
   output msi_msg_t               msg,
   output logic                   take
);

   logic [MSG_ADDR_W-1:0]  addr_c;
   logic [BASE_DATA_W-1:0] low_mask;
   logic [BASE_DATA_W-1:0] vec_ext;
   msi_msg_t               msg_c;

   generate
      if (ADDR64_EN) begin : g_addr64
         assign addr_c = base_addr;
      end else begin : g_addr32
         assign addr_c = {{(MSG_ADDR_W-32){1'b0}}, base_addr[31:0]};
      end
   endgenerate

   assign low_mask = BASE_DATA_W'((32'd1 << eff_log) - 32'd1);
   assign vec_ext  = BASE_DATA_W'(vec);

   always_comb begin
      msg_c.addr = addr_c;
      msg_c.data = {{(MSG_DATA_W-BASE_DATA_W){1'b0}},
                    (base_data & ~low_mask) | (vec_ext & low_mask)};
      msg_c.rid  = rid;
   end

   assign take = go && (!valid || ready);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         msg   <= '0;
      end else if (take) begin
         valid <= 1'b1;
         msg   <= msg_c;
      end else if (ready) begin
         valid <= 1'b0;
      end
   end

   AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
      valid && !ready |=> valid && $stable(msg)); // R6

endmodule

// File: rtl/msi_msg_gen.sv
module msi_msg_gen
   import msi_gen_pkg::*;
#(
   parameter int NUM_VEC   = 32,
   parameter bit MASK_EN   = 1'b1,
   parameter bit ADDR64_EN = 1'b1,
   parameter int LOGF_W    = 3,
   localparam int VEC_W    = $clog2(NUM_VEC)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_enable,
   input  logic [LOGF_W-1:0]      cfg_log_vecs,
   input  logic [MSG_ADDR_W-1:0]  cfg_addr,
   input  logic [BASE_DATA_W-1:0] cfg_data,
   input  logic [NUM_VEC-1:0]     cfg_mask,
   input  logic                   cfg_wr,
   input  logic [RID_W-1:0]       req_id,
   input  logic                   irq_valid,
   input  logic [VEC_W-1:0]       irq_vec,
   output logic                   irq_err,
   output logic [NUM_VEC-1:0]     pend_o,
   input  logic                   intx_i,
   output logic                   intx_o,
   output logic                   msg_valid,
   input  logic                   msg_ready,
   output logic [MSG_ADDR_W-1:0]  msg_addr,
   output logic [MSG_DATA_W-1:0]  msg_data,
   output logic [RID_W-1:0]       msg_rid
);

   localparam int LOG_MAX = VEC_W;

   generate
      if (NUM_VEC < 2 || NUM_VEC > 32 || (NUM_VEC & (NUM_VEC - 1)) != 0) begin : g_bad_num
         $error("NUM_VEC must be a power of two from 2 to 32");
      end
      if ((1 << LOGF_W) <= LOG_MAX) begin : g_bad_logf
         $error("LOGF_W too narrow for log2(NUM_VEC)");
      end
   endgenerate

   logic [LOGF_W-1:0]  eff_log;
   logic [NUM_VEC-1:0] in_range;
   logic               legal;
   logic [NUM_VEC-1:0] req_hit;
   logic [NUM_VEC-1:0] fire;
   logic [NUM_VEC-1:0] gnt;
   logic [NUM_VEC-1:0] launch;
   logic [VEC_W-1:0]   pick_idx;
   logic               pick_any;
   logic               take;
   logic               err_q;
   msi_msg_t           msg;

   assign eff_log = (cfg_log_vecs > LOGF_W'(LOG_MAX)) ? LOGF_W'(LOG_MAX) : cfg_log_vecs;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_VEC; gi++) begin : g_range
         assign in_range[gi] = (32'(gi) < (32'd1 << eff_log));
      end
   endgenerate

   assign legal   = (32'(irq_vec) < (32'd1 << eff_log));
   assign req_hit = (irq_valid && cfg_enable && legal) ? (NUM_VEC'(1) << irq_vec) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_q <= 1'b0;
      end else begin
         err_q <= irq_valid && cfg_enable && !legal;
      end
   end
   assign irq_err = err_q;

   msi_vec_track #(.NUM_VEC(NUM_VEC), .MASK_EN(MASK_EN)) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (cfg_enable),
      .cfg_wr   (cfg_wr),
      .req_hit  (req_hit),
      .mask     (cfg_mask),
      .in_range (in_range),
      .launch   (launch),
      .pend     (pend_o),
      .fire     (fire)
   );

   msi_lowest_pick #(.NUM_VEC(NUM_VEC)) u_pick (
      .req (fire),
      .gnt (gnt),
      .idx (pick_idx),
      .any (pick_any)
   );

   msi_msg_out #(.NUM_VEC(NUM_VEC), .ADDR64_EN(ADDR64_EN), .LOGF_W(LOGF_W)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (pick_any && cfg_enable),
      .vec       (pick_idx),
      .eff_log   (eff_log),
      .base_addr (cfg_addr),
      .base_data (cfg_data),
      .rid       (req_id),
      .ready     (msg_ready),
      .valid     (msg_valid),
      .msg       (msg),
      .take      (take)
   );

   assign launch   = take ? gnt : '0;
   assign msg_addr = msg.addr;
   assign msg_data = msg.data;
   assign msg_rid  = msg.rid;
   assign intx_o   = intx_i && !cfg_enable;

   AST_ILLEGAL_NOSTATE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid && cfg_enable && !legal && !cfg_wr |=> $stable(pend_o)); // R1

   AST_LOWEST_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      pick_any |-> $onehot(gnt) && (((gnt - 1'b1) & fire) == '0)); // R7

   AST_SEND_ONLY_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_enable && !msg_valid |=> !msg_valid); // R11

endmodule

// File: tb/msi_msg_gen_test.sv
`timescale 1ns/1ps
module msi_msg_gen_test;

   localparam int NV = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_enable = 1'b0;
   logic [2:0]  cfg_log_vecs = '0;
   logic [63:0] cfg_addr = '0;
   logic [15:0] cfg_data = '0;
   logic [NV-1:0] cfg_mask = '0;
   logic        cfg_wr = 1'b0;
   logic [15:0] req_id = '0;
   logic        irq_valid = 1'b0;
   logic [4:0]  irq_vec = '0;
   logic        intx_i = 1'b0;
   logic        msg_ready = 1'b0;

   logic        irq_err, intx_o, msg_valid;
   logic [NV-1:0] pend_o;
   logic [63:0] msg_addr;
   logic [31:0] msg_data;
   logic [15:0] msg_rid;

   logic        l_err, l_intx, l_valid;
   logic [NV-1:0] l_pend;
   logic [63:0] l_addr;
   logic [31:0] l_data;
   logic [15:0] l_rid;

   int compared = 0;
   int mismatched = 0;
   int lite_sent = 0;
   bit done = 1'b0;
   logic [31:0] sent_q[$];

   always #10 clk = ~clk;

   msi_msg_gen uut (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_log_vecs(cfg_log_vecs),
      .cfg_addr(cfg_addr), .cfg_data(cfg_data), .cfg_mask(cfg_mask), .cfg_wr(cfg_wr),
      .req_id(req_id), .irq_valid(irq_valid), .irq_vec(irq_vec), .irq_err(irq_err),
      .pend_o(pend_o), .intx_i(intx_i), .intx_o(intx_o), .msg_valid(msg_valid),
      .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data), .msg_rid(msg_rid));

   msi_msg_gen #(.MASK_EN(1'b0), .ADDR64_EN(1'b0)) uut_lite (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_log_vecs(cfg_log_vecs),
      .cfg_addr(cfg_addr), .cfg_data(cfg_data), .cfg_mask(cfg_mask), .cfg_wr(cfg_wr),
      .req_id(req_id), .irq_valid(irq_valid), .irq_vec(irq_vec), .irq_err(l_err),
      .pend_o(l_pend), .intx_i(intx_i), .intx_o(l_intx), .msg_valid(l_valid),
      .msg_ready(msg_ready), .msg_addr(l_addr), .msg_data(l_data), .msg_rid(l_rid));

   // behavioural reference model
   logic [NV-1:0] m_pend, m_fire;
   logic        m_valid, m_err;
   logic [63:0] m_addr;
   logic [31:0] m_data;
   logic [15:0] m_rid;

   function automatic logic [31:0] exp_data(logic [15:0] b, int cnt, int v);
      logic [15:0] m;
      m = 16'(cnt - 1);
      return {16'h0, (b & ~m) | (16'(v) & m)};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pend = '0; m_fire = '0; m_valid = 0; m_err = 0;
         m_addr = '0; m_data = '0; m_rid = '0;
      end else begin
         int eff, cnt;
         bit hs;
         eff = (int'(cfg_log_vecs) > 5) ? 5 : int'(cfg_log_vecs);
         cnt = 1 << eff;
         hs = m_valid && msg_ready;
         if (!m_valid || hs) begin
            m_valid = 0;
            if (cfg_enable) begin
               for (int v = 0; v < NV; v++) begin
                  if (m_fire[v]) begin
                     m_valid = 1; m_fire[v] = 0;
                     m_addr = cfg_addr; m_rid = req_id;
                     m_data = exp_data(cfg_data, cnt, v);
                     break;
                  end
               end
            end
         end
         if (cfg_enable && cfg_wr) begin
            for (int v = 0; v < NV; v++) begin
               if (v >= cnt) m_pend[v] = 0;
               else if (m_pend[v] && !cfg_mask[v]) begin
                  m_pend[v] = 0; m_fire[v] = 1;
               end
            end
         end
         m_err = 0;
         if (irq_valid && cfg_enable) begin
            if (int'(irq_vec) >= cnt) m_err = 1;
            else if (cfg_mask[irq_vec]) m_pend[irq_vec] = 1;
            else m_fire[irq_vec] = 1;
         end
      end
   end

   task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
      if (!ok) begin
         mismatched++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic named(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
      compared++;
      chk(ok, tag, act, exp);
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         compared++;
         chk(msg_valid === m_valid, "R6 msg_valid", 64'(msg_valid), 64'(m_valid));
         if (m_valid) begin
            chk(msg_addr === m_addr, "R5 msg_addr", msg_addr, m_addr);
            chk(msg_data === m_data, "R4 msg_data", 64'(msg_data), 64'(m_data));
            chk(msg_rid === m_rid, "R6 msg_rid", 64'(msg_rid), 64'(m_rid));
         end
         chk(irq_err === m_err, "R1 irq_err", 64'(irq_err), 64'(m_err));
         chk(pend_o === m_pend, "R2 pend_o", 64'(pend_o), 64'(m_pend));
         chk(intx_o === (intx_i && !cfg_enable), "R10 intx_o", 64'(intx_o),
             64'(intx_i && !cfg_enable));
         chk(l_pend === '0, "R3 lite pend_o", 64'(l_pend), 64'h0);
         if (l_valid) chk(l_addr[63:32] === 32'h0, "R5 lite addr upper", 64'(l_addr[63:32]), 64'h0);
         if (msg_valid && msg_ready) sent_q.push_back(msg_data);
         if (l_valid && msg_ready) lite_sent++;
      end
   end

   task automatic step(int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #2;
      end
   endtask

   task automatic irq(int v);
      irq_valid = 1; irq_vec = 5'(v);
      step();
      irq_valid = 0;
   endtask

   task automatic cfg_pulse();
      cfg_wr = 1; step(); cfg_wr = 0;
   endtask

   initial begin
      #(20ns * 200000);
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      int base_lite;
      step(3);
      rst_n = 1;
      @(negedge clk);
      named(msg_valid === 0 && pend_o === '0 && irq_err === 0, "R6 reset state",
            {msg_valid, irq_err, pend_o}, 64'h0);
      step();

      // R11 / R10: disabled
      intx_i = 1; cfg_log_vecs = 3; cfg_mask = 32'h8;
      @(negedge clk);
      named(intx_o === 1, "R10 passthrough while off", 64'(intx_o), 64'h1);
      step();
      irq(3); irq(12); cfg_pulse(); step(4);
      @(negedge clk);
      named(pend_o === '0 && sent_q.size() == 0 && irq_err === 0, "R11 ignored while off",
            {32'(sent_q.size()), pend_o}, 64'h0);
      step();

      // enable, basic send
      cfg_enable = 1; cfg_mask = '0; cfg_data = 16'h1230;
      cfg_addr = 64'h1234_5678_9ABC_DEF0; req_id = 16'h0A5C; msg_ready = 1;
      @(negedge clk);
      named(intx_o === 0, "R10 gated while on", 64'(intx_o), 64'h0);
      step();
      irq(5); step(5);
      named(sent_q.size() == 1 && sent_q[0] == 32'h1235, "R4 vector in low bits",
            sent_q.size() ? 64'(sent_q[0]) : 64'hDEAD, 64'h1235);
      sent_q.delete();

      // R6 stall, R7 lowest first
      msg_ready = 0;
      irq(1); step(2); irq(3); irq(2); step(5);
      msg_ready = 1; step(6);
      named(sent_q.size() == 3 && sent_q[1] == 32'h1232 && sent_q[2] == 32'h1233,
            "R7 queued order", sent_q.size() == 3 ? 64'(sent_q[1]) : 64'hDEAD, 64'h1232);
      sent_q.delete();

      // R1 illegal
      irq_valid = 1; irq_vec = 9; step(); irq_valid = 0;
      @(negedge clk);
      named(irq_err === 1, "R1 error flag", 64'(irq_err), 64'h1);
      step(4);
      named(sent_q.size() == 0 && pend_o === '0, "R1 no side effect", 64'(sent_q.size()), 64'h0);

      // R2 masking
      base_lite = lite_sent;
      cfg_mask = 32'h44;
      irq(2); irq(2); irq(6); step(4);
      named(pend_o === 32'h44, "R2 pending bits", 64'(pend_o), 64'h44);
      named(sent_q.size() == 0, "R2 no message", 64'(sent_q.size()), 64'h0);
      named(lite_sent - base_lite == 3, "R3 lite ignores mask", 64'(lite_sent - base_lite), 64'h3);

      // R8 replay
      cfg_mask = '0; cfg_pulse(); step(6);
      named(sent_q.size() == 2 && sent_q[0] == 32'h1232 && sent_q[1] == 32'h1236,
            "R8 replay ascending", sent_q.size() ? 64'(sent_q[0]) : 64'hDEAD, 64'h1232);
      named(pend_o === '0, "R8 pending cleared", 64'(pend_o), 64'h0);
      sent_q.delete();

      // R9 discard out of range
      cfg_log_vecs = 5; cfg_mask = 32'h0010_0000;
      irq(20); step(2);
      cfg_log_vecs = 2; cfg_mask = '0; cfg_pulse(); step(5);
      named(pend_o === '0 && sent_q.size() == 0, "R9 discarded", {32'(sent_q.size()), pend_o}, 64'h0);

      // R12 clamp
      cfg_log_vecs = 7; irq(31); step(5);
      named(sent_q.size() == 1 && sent_q[0] == 32'h123F, "R12 clamp",
            sent_q.size() ? 64'(sent_q[0]) : 64'hDEAD, 64'h123F);
      sent_q.delete();

      // R4 single vector
      cfg_log_vecs = 0; cfg_data = 16'hBEEF; irq(0); step(5);
      named(sent_q.size() == 1 && sent_q[0] == 32'h0000BEEF, "R4 single vector",
            sent_q.size() ? 64'(sent_q[0]) : 64'hDEAD, 64'hBEEF);
      sent_q.delete();

      // R11 pending frozen while off
      cfg_log_vecs = 3; cfg_mask = 32'h3; irq(1); step();
      cfg_enable = 0; irq(0); cfg_mask = '0; cfg_pulse(); step(3);
      named(pend_o === 32'h2 && sent_q.size() == 0, "R11 pending frozen", 64'(pend_o), 64'h2);
      cfg_enable = 1; cfg_pulse(); step(5);
      named(sent_q.size() == 1, "R8 release after re-enable", 64'(sent_q.size()), 64'h1);

      // mixed traffic against the model
      for (int i = 0; i < 600; i++) begin
         msg_ready = ($urandom_range(0, 3) != 0);
         irq_valid = ($urandom_range(0, 1) == 1);
         irq_vec = 5'($urandom_range(0, 31));
         cfg_wr = ($urandom_range(0, 7) == 0);
         if ($urandom_range(0, 15) == 0) cfg_mask = $urandom();
         if ($urandom_range(0, 31) == 0) cfg_log_vecs = 3'($urandom_range(0, 7));
         cfg_enable = ($urandom_range(0, 19) != 0);
         cfg_data = 16'($urandom());
         intx_i = $urandom_range(0, 1) == 1;
         step();
      end
      irq_valid = 0; cfg_enable = 1; msg_ready = 1; cfg_mask = '0; cfg_wr = 0;
      cfg_pulse(); step(40);
      named(msg_valid === 0 && pend_o === '0, "R8 drained", {msg_valid, pend_o}, 64'h0);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule